// File: doc/BRIEF.md
# Virtually-indexed, physically-tagged level-one data cache lookup

This block is the lookup path of a level-one data cache that selects its set from address bits that translation never changes. Both the set index and the line offset fit inside the 4 KiB page offset. The tags and data of every way in the indexed set can therefore be read while the page number is still being translated. Only the tag comparison waits for the translated page number. Once a way matches, its line is picked and the addressed 64-bit word is returned. Every request gets exactly one response, four cycles after it is presented.

A single write port serves two kinds of write. A fill installs a whole line and its physical tag into a chosen way. A store merges bytes into one word of a line that is already resident. Miss handling is left to the caller: the block only reports the outcome. The translation buffer sits outside the block, and the caller supplies its result during the compare cycle.

Top module: `vipt_l1_lookup`

## Requirements
- R1: With the default geometry (64 sets, 8 ways, 64-byte lines), the set is virtual address bits [11:6] and the 64-bit word within the line is bits [5:3]. Elaboration is refused when sets × line bytes exceeds 4096.
- R2: A request presented in cycle C gives rsp_valid high in cycle C+4 only, with rsp_valid low in C+3. Requests may be presented in consecutive cycles, and each gets its own response in order.
- R3: A hit is reported when exactly one valid way of the set holds a tag equal to xlat_ppn. rsp_way is that way's binary index, and rsp_data is line bytes [8w+7:8w] for w = 8·vaddr[5:3] … 8·vaddr[5:3]+7, little-endian.
- R4: When no valid way matches, rsp_miss is high and both rsp_data and rsp_way are zero.
- R5: If xlat_valid is low in cycle C+2 (the compare cycle), the response is a replay, whatever the tags hold.
- R6: If two or more valid ways match, rsp_err is high and hit, miss and replay are low.
- R7: A fill (wr_en high, wr_store low) writes wr_line, with byte b at bits [8b+7:8b], and the tag wr_tag into way wr_way of set wr_set. It also marks that way valid.
- R8: A store (wr_en high, wr_store high) replaces only the bytes of word wr_word whose wr_be bit is set (bit k means byte k of the word). It leaves the other bytes, the other words and the tag unchanged.
- R9: A write of either kind to the request's set in cycle C+1 (the array read cycle) takes effect, and the request is answered with a replay. A write to another set in that cycle does not disturb the request.
- R10: Virtual address bits above bit 11 have no effect on the response.
- R11: Reset clears every valid bit and every response output, so a lookup after reset misses.
- R12: While rsp_valid is high, exactly one of rsp_hit, rsp_miss, rsp_replay and rsp_err is high. While it is low, all four are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 48 | Virtual address of the load |
| xlat_valid | input | 1 | Translation result present (compare cycle) |
| xlat_ppn | input | 28 | Physical page number from translation |
| wr_en | input | 1 | Write port enable |
| wr_store | input | 1 | 1 = byte store, 0 = line fill |
| wr_set | input | 6 | Set written |
| wr_way | input | 3 | Way written |
| wr_tag | input | 28 | Physical tag for a fill |
| wr_line | input | 512 | Line data for a fill |
| wr_word | input | 3 | Word within the line for a store |
| wr_wdata | input | 64 | Store data |
| wr_be | input | 8 | Store byte enables |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Single-way match |
| rsp_miss | output | 1 | No way matched |
| rsp_replay | output | 1 | Request must be reissued |
| rsp_err | output | 1 | Multi-way match |
| rsp_way | output | 3 | Hit way index |
| rsp_data | output | 64 | Load data |

## Verification
The bench plants the same tag in two ways of one set. A design that returned the first match would report a hit, where rsp_err is expected. It withdraws xlat_valid in the compare cycle only, which exposes a design that samples translation in the wrong cycle or lets a hit through. It writes the request's set during the read cycle, which catches a design that returns stale data instead of replaying. It also writes another set in that cycle, which catches a design that replays too often. It also covers the lowest and highest sets, partial byte masks, changed upper virtual bits and back-to-back requests. These catch an index taken from the wrong bits, a store that overwrites the whole word, and a pipeline that loses its second response.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    localparam int unsigned PAGE_OFF_W     = 12;
    localparam int unsigned PAGE_BYTES     = 4096;
    localparam int unsigned DEF_SETS       = 64;
    localparam int unsigned DEF_WAYS       = 8;
    localparam int unsigned DEF_LINE_BYTES = 64;
    localparam int unsigned DEF_WORD_BYTES = 8;
    localparam int unsigned DEF_PA_W       = 40;
    localparam int unsigned DEF_VA_W       = 48;

    typedef enum logic [2:0] {
        OUT_NONE,
        OUT_HIT,
        OUT_MISS,
        OUT_REPLAY,
        OUT_ERR
    } outcome_e;

    // Blocking conditions win, then ambiguity, then a clean hit.
    function automatic outcome_e classify(input logic blocked,
                                          input logic any_match,
                                          input logic multi_match);
        if (blocked)          return OUT_REPLAY;
        else if (multi_match) return OUT_ERR;
        else if (any_match)   return OUT_HIT;
        else                  return OUT_MISS;
    endfunction

endpackage

// File: rtl/vipt_tag_array.sv
module vipt_tag_array #(
    parameter int unsigned SETS  = 64,
    parameter int unsigned WAYS  = 8,
    parameter int unsigned TAG_W = 28,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        fill_en,
    input  logic [IDX_W-1:0]            fill_set,
    input  logic [WAY_W-1:0]            fill_way,
    input  logic [TAG_W-1:0]            fill_tag,
    input  logic [IDX_W-1:0]            rd_set,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tags,
    output logic [WAYS-1:0]             rd_vld
);

    logic [TAG_W-1:0] tag_mem [SETS][WAYS];
    logic [WAYS-1:0]  vld_mem [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) vld_mem[s] <= '0;
            rd_vld <= '0;
        end else begin
            if (fill_en) vld_mem[fill_set][fill_way] <= 1'b1;
            rd_vld <= vld_mem[rd_set];
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_mem[fill_set][fill_way] <= fill_tag;
        for (int w = 0; w < WAYS; w++) rd_tags[w] <= tag_mem[rd_set][w];
    end

endmodule

// File: rtl/vipt_data_array.sv
module vipt_data_array #(
    parameter int unsigned SETS       = 64,
    parameter int unsigned WAYS       = 8,
    parameter int unsigned LINE_BYTES = 64,
    parameter int unsigned WORD_BYTES = 8,
    localparam int unsigned IDX_W     = $clog2(SETS),
    localparam int unsigned WAY_W     = $clog2(WAYS),
    localparam int unsigned LINE_BITS = LINE_BYTES * 8,
    localparam int unsigned WORD_W    = WORD_BYTES * 8,
    localparam int unsigned WSEL_W    = $clog2(LINE_BYTES / WORD_BYTES)
) (
    input  logic                           clk,
    input  logic                           wr_en,
    input  logic                           wr_store,
    input  logic [IDX_W-1:0]               wr_set,
    input  logic [WAY_W-1:0]               wr_way,
    input  logic [LINE_BITS-1:0]           wr_line,
    input  logic [WSEL_W-1:0]              wr_word,
    input  logic [WORD_W-1:0]              wr_wdata,
    input  logic [WORD_BYTES-1:0]          wr_be,
    input  logic [IDX_W-1:0]               rd_set,
    output logic [WAYS-1:0][LINE_BITS-1:0] rd_lines
);

    logic [LINE_BITS-1:0] line_mem [SETS][WAYS];
    logic [LINE_BITS-1:0] merged;

    // A fill takes every byte; a store takes only enabled bytes of its word.
    always_comb begin
        merged = line_mem[wr_set][wr_way];
        for (int b = 0; b < LINE_BYTES; b++) begin
            if (!wr_store)
                merged[b*8 +: 8] = wr_line[b*8 +: 8];
            else if (wr_word == WSEL_W'(b / WORD_BYTES) && wr_be[b % WORD_BYTES])
                merged[b*8 +: 8] = wr_wdata[(b % WORD_BYTES)*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) line_mem[wr_set][wr_way] <= merged;
        for (int w = 0; w < WAYS; w++) rd_lines[w] <= line_mem[rd_set][w];
    end

endmodule

// File: rtl/vipt_way_match.sv
module vipt_way_match #(
    parameter int unsigned WAYS  = 8,
    parameter int unsigned TAG_W = 28,
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [WAYS-1:0]            vld,
    input  logic [TAG_W-1:0]           ppn,
    output logic                       any_match,
    output logic                       multi_match,
    output logic [WAY_W-1:0]           match_way
);

    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = vld[w] && (tags[w] == ppn);
    end

    always_comb begin
        match_way = '0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (match[w]) match_way = WAY_W'(w);
    end

    assign any_match   = |match;
    assign multi_match = |(match & (match - 1'b1));

endmodule

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup
    import vipt_pkg::*;
#(
    parameter int unsigned SETS       = DEF_SETS,
    parameter int unsigned WAYS       = DEF_WAYS,
    parameter int unsigned LINE_BYTES = DEF_LINE_BYTES,
    parameter int unsigned WORD_BYTES = DEF_WORD_BYTES,
    parameter int unsigned PA_W       = DEF_PA_W,
    parameter int unsigned VA_W       = DEF_VA_W,
    localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
    localparam int unsigned IDX_W     = $clog2(SETS),
    localparam int unsigned WAY_W     = $clog2(WAYS),
    localparam int unsigned LINE_BITS = LINE_BYTES * 8,
    localparam int unsigned WORD_W    = WORD_BYTES * 8,
    localparam int unsigned BSEL_W    = $clog2(WORD_BYTES),
    localparam int unsigned WSEL_W    = $clog2(LINE_BYTES / WORD_BYTES),
    localparam int unsigned PPN_W     = PA_W - PAGE_OFF_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic                  xlat_valid,
    input  logic [PPN_W-1:0]      xlat_ppn,
    input  logic                  wr_en,
    input  logic                  wr_store,
    input  logic [IDX_W-1:0]      wr_set,
    input  logic [WAY_W-1:0]      wr_way,
    input  logic [PPN_W-1:0]      wr_tag,
    input  logic [LINE_BITS-1:0]  wr_line,
    input  logic [WSEL_W-1:0]     wr_word,
    input  logic [WORD_W-1:0]     wr_wdata,
    input  logic [WORD_BYTES-1:0] wr_be,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic                  rsp_miss,
    output logic                  rsp_replay,
    output logic                  rsp_err,
    output logic [WAY_W-1:0]      rsp_way,
    output logic [WORD_W-1:0]     rsp_data
);

    // Index and offset must come from untranslated bits.
    if (SETS * LINE_BYTES > PAGE_BYTES) begin : g_geom_bad
        $error("set index plus line offset reach beyond the page offset");
    end

    typedef struct packed {
        logic              vld;
        logic [IDX_W-1:0]  idx;
        logic [WSEL_W-1:0] wsel;
    } rd_stage_t;

    typedef struct packed {
        logic              vld;
        logic              blocked;
        logic [WSEL_W-1:0] wsel;
    } cmp_stage_t;

    typedef struct packed {
        logic              vld;
        outcome_e          out;
        logic [WAY_W-1:0]  way;
        logic [WSEL_W-1:0] wsel;
    } sel_stage_t;

    rd_stage_t  s1;
    cmp_stage_t s2;
    sel_stage_t s3;
    logic [LINE_BITS-1:0] s3_line;

    logic [WAYS-1:0][PPN_W-1:0]     rd_tags;
    logic [WAYS-1:0]                rd_vld;
    logic [WAYS-1:0][LINE_BITS-1:0] rd_lines;
    logic                           any_match, multi_match;
    logic [WAY_W-1:0]               match_way;
    outcome_e                       s2_out;

    vipt_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(PPN_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .fill_en  (wr_en && !wr_store),
        .fill_set (wr_set),
        .fill_way (wr_way),
        .fill_tag (wr_tag),
        .rd_set   (s1.idx),
        .rd_tags  (rd_tags),
        .rd_vld   (rd_vld)
    );

    vipt_data_array #(.SETS(SETS), .WAYS(WAYS), .LINE_BYTES(LINE_BYTES),
                      .WORD_BYTES(WORD_BYTES)) u_data (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_store (wr_store),
        .wr_set   (wr_set),
        .wr_way   (wr_way),
        .wr_line  (wr_line),
        .wr_word  (wr_word),
        .wr_wdata (wr_wdata),
        .wr_be    (wr_be),
        .rd_set   (s1.idx),
        .rd_lines (rd_lines)
    );

    vipt_way_match #(.WAYS(WAYS), .TAG_W(PPN_W)) u_match (
        .tags        (rd_tags),
        .vld         (rd_vld),
        .ppn         (xlat_ppn),
        .any_match   (any_match),
        .multi_match (multi_match),
        .match_way   (match_way)
    );

    assign s2_out = classify(s2.blocked || !xlat_valid, any_match, multi_match);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
            s3 <= '{vld: 1'b0, out: OUT_NONE, way: '0, wsel: '0};
        end else begin
            s1.vld  <= req_valid;
            s1.idx  <= req_vaddr[OFF_W +: IDX_W];
            s1.wsel <= req_vaddr[BSEL_W +: WSEL_W];

            s2.vld     <= s1.vld;
            s2.blocked <= wr_en && (wr_set == s1.idx);
            s2.wsel    <= s1.wsel;

            s3.vld  <= s2.vld;
            s3.out  <= s2.vld ? s2_out : OUT_NONE;
            s3.way  <= match_way;
            s3.wsel <= s2.wsel;
        end
    end

    always_ff @(posedge clk) s3_line <= rd_lines[match_way];

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_miss   <= 1'b0;
            rsp_replay <= 1'b0;
            rsp_err    <= 1'b0;
            rsp_way    <= '0;
            rsp_data   <= '0;
        end else begin
            rsp_valid  <= s3.vld;
            rsp_hit    <= s3.vld && s3.out == OUT_HIT;
            rsp_miss   <= s3.vld && s3.out == OUT_MISS;
            rsp_replay <= s3.vld && s3.out == OUT_REPLAY;
            rsp_err    <= s3.vld && s3.out == OUT_ERR;
            rsp_way    <= (s3.vld && s3.out == OUT_HIT) ? s3.way : '0;
            rsp_data   <= (s3.vld && s3.out == OUT_HIT)
                          ? s3_line[s3.wsel * WORD_W +: WORD_W] : '0;
        end
    end

endmodule

// File: rtl/vipt_l1_lookup_chk.sv
module vipt_l1_lookup_chk #(
    parameter int unsigned VA_W   = 48,
    parameter int unsigned IDX_LO = 6,
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned WAY_W  = 3,
    parameter int unsigned WORD_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [VA_W-1:0]   req_vaddr,
    input logic              xlat_valid,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_set,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_miss,
    input logic              rsp_replay,
    input logic              rsp_err,
    input logic [WAY_W-1:0]  rsp_way,
    input logic [WORD_W-1:0] rsp_data
);

    logic [2:0]       since_rst;
    logic             warm;
    logic [IDX_W-1:0] req_set;

    assign req_set = req_vaddr[IDX_LO +: IDX_W];
    assign warm    = since_rst >= 3'd4;

    always_ff @(posedge clk) begin
        if (rst)        since_rst <= '0;
        else if (!warm) since_rst <= since_rst + 3'd1;
    end

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        warm |-> (rsp_valid == $past(req_valid, 4)));

    // R12
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_replay, rsp_err}));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_replay || rsp_err));

    // R5
    xlat_replay_chk: assert property (@(posedge clk) disable iff (rst)
        (warm && rsp_valid && !$past(xlat_valid, 2)) |-> rsp_replay);

    // R9
    wr_conflict_chk: assert property (@(posedge clk) disable iff (rst)
        (warm && rsp_valid && $past(wr_en, 3) && ($past(wr_set, 3) == $past(req_set, 4)))
            |-> rsp_replay);

    // R3
    hit_needs_xlat_chk: assert property (@(posedge clk) disable iff (rst)
        (warm && rsp_hit) |-> $past(xlat_valid, 2));

    // R4
    nonhit_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_data == '0 && rsp_way == '0));

endmodule

bind vipt_l1_lookup vipt_l1_lookup_chk #(
    .VA_W(VA_W), .IDX_LO(OFF_W), .IDX_W(IDX_W), .WAY_W(WAY_W), .WORD_W(WORD_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .xlat_valid (xlat_valid),
    .wr_en      (wr_en),
    .wr_set     (wr_set),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_miss   (rsp_miss),
    .rsp_replay (rsp_replay),
    .rsp_err    (rsp_err),
    .rsp_way    (rsp_way),
    .rsp_data   (rsp_data)
);

// File: tb/vipt_l1_lookup_test.sv
`timescale 1ns/1ps
module vipt_l1_lookup_test;

    localparam time CLK_P = 20ns;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic [47:0]  req_vaddr = '0;
    logic         xlat_valid = 1'b0;
    logic [27:0]  xlat_ppn = '0;
    logic         wr_en = 1'b0;
    logic         wr_store = 1'b0;
    logic [5:0]   wr_set = '0;
    logic [2:0]   wr_way = '0;
    logic [27:0]  wr_tag = '0;
    logic [511:0] wr_line = '0;
    logic [2:0]   wr_word = '0;
    logic [63:0]  wr_wdata = '0;
    logic [7:0]   wr_be = '0;
    logic         rsp_valid, rsp_hit, rsp_miss, rsp_replay, rsp_err;
    logic [2:0]   rsp_way;
    logic [63:0]  rsp_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // results of the last lookup
    logic        r_early, r_vld, r_hit, r_miss, r_rep, r_err;
    logic [2:0]  r_way;
    logic [63:0] r_data;

    always #(CLK_P/2) clk = ~clk;

    vipt_l1_lookup uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .xlat_valid(xlat_valid), .xlat_ppn(xlat_ppn), .wr_en(wr_en),
        .wr_store(wr_store), .wr_set(wr_set), .wr_way(wr_way), .wr_tag(wr_tag),
        .wr_line(wr_line), .wr_word(wr_word), .wr_wdata(wr_wdata), .wr_be(wr_be),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_replay(rsp_replay), .rsp_err(rsp_err), .rsp_way(rsp_way),
        .rsp_data(rsp_data)
    );

    function automatic logic [511:0] mkline(input int seed);
        logic [511:0] l;
        for (int b = 0; b < 64; b++) l[b*8 +: 8] = 8'((seed * 13 + b * 5 + 1) & 255);
        return l;
    endfunction

    function automatic logic [63:0] word_of(input logic [511:0] l, input int w);
        return l[w*64 +: 64];
    endfunction

    function automatic logic [47:0] mkva(input logic [35:0] hi, input int set, input int w);
        return {hi, 6'(set), 3'(w), 3'b000};
    endfunction

    task automatic chk(input string rq, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, got, exp);
        end
    endtask

    task automatic fill(input int set, input int way, input logic [27:0] tag, input int seed);
        @(negedge clk);
        wr_en = 1'b1; wr_store = 1'b0; wr_set = 6'(set); wr_way = 3'(way);
        wr_tag = tag; wr_line = mkline(seed);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic store(input int set, input int way, input int w,
                         input logic [63:0] d, input logic [7:0] be);
        @(negedge clk);
        wr_en = 1'b1; wr_store = 1'b1; wr_set = 6'(set); wr_way = 3'(way);
        wr_word = 3'(w); wr_wdata = d; wr_be = be;
        @(negedge clk);
        wr_en = 1'b0; wr_store = 1'b0;
    endtask

    // Request in cycle C; optional fill in C+1; xlat_valid forced to xv in C+2.
    task automatic lookup(input logic [47:0] va, input logic [27:0] ppn, input bit xv,
                          input bit cw, input int cw_set, input int cw_way,
                          input logic [27:0] cw_tag, input int cw_seed);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; xlat_valid = 1'b1; xlat_ppn = ppn;
        @(negedge clk);
        req_valid = 1'b0;
        if (cw) begin
            wr_en = 1'b1; wr_store = 1'b0; wr_set = 6'(cw_set); wr_way = 3'(cw_way);
            wr_tag = cw_tag; wr_line = mkline(cw_seed);
        end
        @(negedge clk);
        wr_en = 1'b0;
        xlat_valid = xv;
        @(negedge clk);
        xlat_valid = 1'b1;
        r_early = rsp_valid;
        @(negedge clk);
        r_vld = rsp_valid; r_hit = rsp_hit; r_miss = rsp_miss; r_rep = rsp_replay;
        r_err = rsp_err; r_way = rsp_way; r_data = rsp_data;
    endtask

    task automatic plain(input logic [47:0] va, input logic [27:0] ppn);
        lookup(va, ppn, 1'b1, 1'b0, 0, 0, '0, 0);
    endtask

    task automatic expect_hit(input string rq, input int way, input logic [63:0] d);
        chk(rq, "valid", {63'd0, r_vld}, 64'd1);
        chk(rq, "hit",   {63'd0, r_hit}, 64'd1);
        chk(rq, "way",   {61'd0, r_way}, 64'(way));
        chk(rq, "data",  r_data, d);
    endtask

    localparam logic [27:0] TAG_A = 28'hABCDE12;
    localparam logic [27:0] TAG_B = 28'h0000777;
    localparam logic [27:0] TAG_C = 28'h5A5A5A5;
    localparam logic [27:0] TAG_D = 28'hFFFFFFF;

    task automatic t_reset;
        chk("R11", "rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        plain(mkva(36'h1, 5, 2), TAG_A);
        chk("R11", "miss on empty cache", {63'd0, r_miss}, 64'd1);
        chk("R4", "miss data zero", r_data, 64'd0);
    endtask

    task automatic t_fill_hit;
        fill(5, 3, TAG_A, 1);
        plain(mkva(36'h1, 5, 2), TAG_A);
        chk("R2", "no response in C+3", {63'd0, r_early}, 64'd0);
        // R3 R7
        expect_hit("R3", 3, word_of(mkline(1), 2));
        plain(mkva(36'h1, 5, 7), TAG_A);
        expect_hit("R7", 3, word_of(mkline(1), 7));
    endtask

    task automatic t_miss;
        plain(mkva(36'h1, 5, 2), TAG_B);
        chk("R4", "miss", {63'd0, r_miss}, 64'd1);
        chk("R4", "way zero", {61'd0, r_way}, 64'd0);
        chk("R4", "data zero", r_data, 64'd0);
    endtask

    task automatic t_upper_va;
        plain(mkva(36'hFEDCBA987, 5, 2), TAG_A);
        expect_hit("R10", 3, word_of(mkline(1), 2));
    endtask

    task automatic t_xlat_replay;
        lookup(mkva(36'h1, 5, 2), TAG_A, 1'b0, 1'b0, 0, 0, '0, 0);
        chk("R5", "replay", {63'd0, r_rep}, 64'd1);
        chk("R5", "not hit", {63'd0, r_hit}, 64'd0);
    endtask

    task automatic t_store;
        logic [63:0] old2;
        logic [63:0] d;
        old2 = word_of(mkline(1), 2);
        d = 64'h1122334455667788;
        store(5, 3, 2, d, 8'h0F);
        plain(mkva(36'h1, 5, 2), TAG_A);
        expect_hit("R8", 3, {old2[63:32], d[31:0]});
        plain(mkva(36'h1, 5, 3), TAG_A);
        expect_hit("R8", 3, word_of(mkline(1), 3));
        store(5, 3, 3, 64'hCAFEF00D00000000, 8'h80);
        plain(mkva(36'h1, 5, 3), TAG_A);
        expect_hit("R8", 3, {8'hCA, word_of(mkline(1), 3)[55:0]});
    endtask

    task automatic t_multi;
        fill(5, 6, TAG_A, 9);
        plain(mkva(36'h1, 5, 2), TAG_A);
        chk("R6", "err", {63'd0, r_err}, 64'd1);
        chk("R6", "hit low", {63'd0, r_hit}, 64'd0);
    endtask

    task automatic t_conflict;
        lookup(mkva(36'h1, 5, 1), TAG_A, 1'b1, 1'b1, 5, 6, TAG_C, 2);
        chk("R9", "same-set write replays", {63'd0, r_rep}, 64'd1);
        plain(mkva(36'h1, 5, 1), TAG_C);
        expect_hit("R9", 6, word_of(mkline(2), 1));
        lookup(mkva(36'h1, 5, 0), TAG_A, 1'b1, 1'b1, 9, 0, TAG_B, 5);
        expect_hit("R9", 3, word_of(mkline(1), 0));
    endtask

    task automatic t_boundary;
        fill(63, 7, TAG_D, 3);
        fill(0, 0, TAG_D, 4);
        plain(mkva(36'h2, 63, 7), TAG_D);
        expect_hit("R1", 7, word_of(mkline(3), 7));
        plain(mkva(36'h2, 0, 0), TAG_D);
        expect_hit("R1", 0, word_of(mkline(4), 0));
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = mkva(36'h3, 63, 4); xlat_valid = 1'b1; xlat_ppn = TAG_D;
        @(negedge clk);
        req_vaddr = mkva(36'h3, 0, 5);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R2", "first response valid", {63'd0, rsp_valid}, 64'd1);
        chk("R2", "first response data", rsp_data, word_of(mkline(3), 4));
        @(negedge clk);
        chk("R2", "second response valid", {63'd0, rsp_valid}, 64'd1);
        chk("R2", "second response way", {61'd0, rsp_way}, 64'd0);
        chk("R2", "second response data", rsp_data, word_of(mkline(4), 5));
        @(negedge clk);
        chk("R12", "quiet after burst",
            {60'd0, rsp_valid, rsp_hit, rsp_miss, rsp_replay}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fill_hit();
        t_miss();
        t_upper_va();
        t_xlat_replay();
        t_store();
        t_multi();
        t_conflict();
        t_boundary();
        t_back_to_back();
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule